// File: doc/BRIEF.md
# Least-Squares Zero-Crossing Timestamper

This block measures the phase difference between two low-frequency beat sines. Each sine is a decimated, signed sample stream from one branch of a dual-mixer phase comparator. The two channels run side by side. On every rising zero crossing, a channel fits a straight line by least squares to a window of samples centred on the sign change. It then solves that line for the sub-sample time at which it reaches zero.

The zero reference is not a fixed threshold. It is the truncated mean of the signal over the last complete span between two falling crossings, so slow converter offset drift cancels out. Each crossing time is an integer sample index with a 16-bit fraction appended. The block pairs channel A and channel B crossings from the same beat period and emits their difference. Nominal use is a beat near 10 Hz sampled at about 2 kS/s, which gives about 200 samples per period. One shared strobe marks a new sample pair.

Top module: `lsq_crossing_timer`

## Requirements
- R1: Only rising crossings produce timestamps; a falling crossing never does.
- R2: The crossing offset is computed with the sign-change sample at x = 0 and the 32 samples x = -16..+15 with zero level subtracted. The slope and intercept come from a least-squares fit, and the offset is -intercept/slope in Q.16, truncated toward zero.
- R3: The zero level starts at 0. It changes only at a falling crossing, after at least one earlier falling crossing has been seen. Its new value is the mean, truncated toward zero, of the samples from the earlier falling-crossing sample up to but not including the current one. The new value applies from the next sample.
- R4: A rising crossing needs the channel in its low state, the previous sample below the zero level and the current sample at or above it. A falling crossing needs the high state and a sample below zero level minus `hyst`.
- R5: Until a channel has seen two falling crossings after reset, it produces no timestamps.
- R6: A timestamp equals sample_index * 2^16 + offset, modulo 2^48. The sample index counts strobes from 0 after reset.
- R7: When a crossing completes a pair, `diff_out` = A timestamp - B timestamp. `diff_valid` pulses for one cycle, one cycle after the completing timestamp.
- R8: A channel that delivers a second crossing while the other has none pending drops its older one and pulses `overrun`. Crossings from both channels in the same cycle pair with each other and discard any stale pending one, also pulsing `overrun`.
- R9: During and right after reset, `diff_valid` and `overrun` are low.
- R10: Noise excursions smaller than `hyst` around the zero level do not create extra crossings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_valid | input | 1 | New sample pair strobe (gap of at least DIV_W+6 cycles) |
| smp_a | input | SMP_W | Channel A signed sample |
| smp_b | input | SMP_W | Channel B signed sample |
| hyst | input | SMP_W | Falling-crossing hysteresis in LSBs |
| diff_valid | output | 1 | One-cycle strobe for diff_out |
| diff_out | output | TS_W+FRAC_W | Signed A-minus-B crossing time, 32.16 |
| overrun | output | 1 | One-cycle pulse when a pending crossing is dropped |

## Verification
The bench sweeps channel phase lead and lag, DC offsets, dither amplitude and hysteresis. It also runs a case in which channel B goes flat mid-run. It checks every difference against an arithmetic model of the fit.

A design that took the zero level from the wrong span, or applied it one sample early, would shift every offset. A design that emitted results before two falling crossings would produce extra differences at the start. A wrong window alignment or fit sign would skew the fractional part. Without hysteresis, dithered runs would yield spurious pairs. The flat-channel case shows whether stale crossings are dropped and flagged instead of being paired across periods.

// File: rtl/lsq_pkg.sv
// Shared constants and types for the crossing timestamper.
// Assumes a fit window of x = -half .. half-1.
package lsq_pkg;

    // Sum of the window abscissae.
    function automatic longint win_sum_x(input int half);
        longint s;
        s = 0;
        for (int x = -half; x < half; x++) s += x;
        return s;
    endfunction

    // Sum of the squared window abscissae.
    function automatic longint win_sum_xx(input int half);
        longint s;
        s = 0;
        for (int x = -half; x < half; x++) s += longint'(x) * x;
        return s;
    endfunction

    typedef enum logic [1:0] {FIT_IDLE, FIT_FILL, FIT_SUM, FIT_DIV} fit_state_e;

endpackage

// File: rtl/lsq_seq_div.sv
// Sequential signed divider, one quotient bit per cycle (restoring).
// Quotient truncates toward zero and is reduced to OUT_W bits.
// Assumes start is only pulsed while busy is low; divide by zero gives all ones magnitude.
module lsq_seq_div #(
    parameter int W     = 64,
    parameter int OUT_W = 48
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic signed [W-1:0]     dividend,
    input  logic signed [W-1:0]     divisor,
    output logic                    busy,
    output logic                    done,
    output logic signed [OUT_W-1:0] quotient
);
    localparam int CNT_W = $clog2(W + 1);

    logic [W-1:0]     quo;
    logic [W-1:0]     mag_d;
    logic [W:0]       rem;
    logic             neg;
    logic [CNT_W-1:0] cnt;
    logic [W:0]       shifted;
    logic             fits;
    logic [W-1:0]     signed_q;

    // One restoring step on the current remainder.
    always_comb begin
        shifted = {rem[W-1:0], quo[W-1]};
        fits    = shifted >= {1'b0, mag_d};
    end

    // Load operands, then iterate W times.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            quo   <= '0;
            mag_d <= '0;
            rem   <= '0;
            neg   <= 1'b0;
            cnt   <= '0;
            busy  <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start && !busy) begin
                quo   <= dividend[W-1] ? W'(-dividend) : W'(dividend);
                mag_d <= divisor[W-1] ? W'(-divisor) : W'(divisor);
                rem   <= '0;
                neg   <= dividend[W-1] ^ divisor[W-1];
                cnt   <= CNT_W'(W);
                busy  <= 1'b1;
            end else if (busy) begin
                rem <= fits ? shifted - {1'b0, mag_d} : shifted;
                quo <= {quo[W-2:0], fits};
                cnt <= cnt - CNT_W'(1);
                if (cnt == CNT_W'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    // Apply the sign to the magnitude.
    always_comb begin
        signed_q = neg ? W'(-quo) : quo;
        quotient = OUT_W'(signed_q);
    end
endmodule

// File: rtl/lsq_chan.sv
// One channel: zero-level tracking from falling-to-falling means, rising-edge
// detection with hysteresis, a 2*HALF sample window and a least-squares
// crossing solve producing a TS_W.FRAC_W timestamp.
// Assumes HALF >= 2 and that samples are spaced further apart than the divider latency.
module lsq_chan
    import lsq_pkg::*;
#(
    parameter int SMP_W  = 16,
    parameter int HALF   = 16,
    parameter int FRAC_W = 16,
    parameter int TS_W   = 32,
    parameter int DIV_W  = 64
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           smp_valid,
    input  logic signed [SMP_W-1:0]        smp,
    input  logic [SMP_W-1:0]               hyst,
    output logic                           zero_ok,
    output logic                           ts_valid,
    output logic signed [TS_W+FRAC_W-1:0]  ts
);
    localparam int WIN    = 2 * HALF;
    localparam int TSF_W  = TS_W + FRAC_W;
    localparam int EXT_W  = SMP_W + 2;
    localparam int LEFT_W = $clog2(HALF + 1);
    localparam longint SX  = win_sum_x(HALF);
    localparam longint SXX = win_sum_xx(HALF);
    localparam logic signed [DIV_W-1:0] SX_V  = DIV_W'(SX);
    localparam logic signed [DIV_W-1:0] NW_V  = DIV_W'(WIN);
    localparam logic signed [DIV_W-1:0] DEN_V = DIV_W'(longint'(WIN) * SXX - SX * SX);
    localparam logic signed [TSF_W-1:0] HALF_ONE = TSF_W'(longint'(1) << (FRAC_W - 1));

    logic [TS_W-1:0]          idx;
    logic signed [SMP_W-1:0]  prev;
    logic                     hi_state;
    logic signed [SMP_W-1:0]  z;
    logic                     rise, fall;
    logic signed [EXT_W-1:0]  cur_e, prev_e, z_e, zlo;

    logic                     started;
    logic signed [DIV_W-1:0]  acc_sum;
    logic [TS_W-1:0]          acc_cnt;
    logic                     m_start, m_busy, m_done;
    logic signed [DIV_W-1:0]  m_num, m_den;
    logic signed [SMP_W-1:0]  m_q;

    logic signed [SMP_W-1:0]  hist [WIN];
    fit_state_e               fst;
    logic [LEFT_W-1:0]        left;
    logic [TS_W-1:0]          center;
    logic signed [SMP_W-1:0]  wz;
    logic signed [DIV_W-1:0]  sy, sxy, fnum_c, fden_c;
    logic                     f_start, f_busy, f_done;
    logic signed [DIV_W-1:0]  f_num, f_den;
    logic signed [TSF_W-1:0]  f_q;

    // Edge conditions against the current zero level.
    always_comb begin
        cur_e  = EXT_W'(smp);
        prev_e = EXT_W'(prev);
        z_e    = EXT_W'(z);
        zlo    = z_e - $signed({2'b00, hyst});
        rise   = smp_valid && !hi_state && (prev_e < z_e) && (cur_e >= z_e);
        fall   = smp_valid && hi_state && (cur_e < zlo);
    end

    // Sample index, previous sample and high/low state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx      <= '0;
            prev     <= '0;
            hi_state <= 1'b0;
        end else if (smp_valid) begin
            idx  <= idx + TS_W'(1);
            prev <= smp;
            if (rise) hi_state <= 1'b1;
            if (fall) hi_state <= 1'b0;
        end
    end

    // Accumulate samples between falling crossings and launch the mean division.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            started <= 1'b0;
            acc_sum <= '0;
            acc_cnt <= '0;
            m_start <= 1'b0;
            m_num   <= '0;
            m_den   <= '0;
        end else begin
            m_start <= 1'b0;
            if (fall) begin
                if (started) begin
                    m_start <= 1'b1;
                    m_num   <= acc_sum;
                    m_den   <= DIV_W'(acc_cnt);
                end
                started <= 1'b1;
                acc_sum <= DIV_W'(smp);
                acc_cnt <= TS_W'(1);
            end else if (smp_valid && started) begin
                acc_sum <= acc_sum + DIV_W'(smp);
                acc_cnt <= acc_cnt + TS_W'(1);
            end
        end
    end

    lsq_seq_div #(.W(DIV_W), .OUT_W(SMP_W)) mean_div_i (
        .clk(clk), .rst_n(rst_n), .start(m_start),
        .dividend(m_num), .divisor(m_den),
        .busy(m_busy), .done(m_done), .quotient(m_q)
    );

    // Take a finished mean as the new zero level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            z       <= '0;
            zero_ok <= 1'b0;
        end else if (m_done) begin
            z       <= m_q;
            zero_ok <= 1'b1;
        end
    end

    // Window history, newest sample at index 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < WIN; k++) hist[k] <= '0;
        end else if (smp_valid) begin
            hist[0] <= smp;
            for (int k = 1; k < WIN; k++) hist[k] <= hist[k-1];
        end
    end

    // Window sums of y and x*y with the latched zero level removed.
    always_comb begin
        logic signed [DIV_W-1:0] dv;
        sy  = '0;
        sxy = '0;
        for (int k = 0; k < WIN; k++) begin
            dv  = DIV_W'(hist[k]) - DIV_W'(wz);
            sy  = sy + dv;
            sxy = sxy + dv * DIV_W'(HALF - 1 - k);
        end
        fnum_c = (sy * DEN_V) <<< FRAC_W;
        fden_c = NW_V * (NW_V * sxy - SX_V * sy);
    end

    lsq_seq_div #(.W(DIV_W), .OUT_W(TSF_W)) fit_div_i (
        .clk(clk), .rst_n(rst_n), .start(f_start),
        .dividend(f_num), .divisor(f_den),
        .busy(f_busy), .done(f_done), .quotient(f_q)
    );

    // Fit sequencer: arm on rise, fill the window, divide, publish timestamp.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fst      <= FIT_IDLE;
            left     <= '0;
            center   <= '0;
            wz       <= '0;
            f_start  <= 1'b0;
            f_num    <= '0;
            f_den    <= '0;
            ts_valid <= 1'b0;
            ts       <= '0;
        end else begin
            f_start  <= 1'b0;
            ts_valid <= 1'b0;
            case (fst)
                FIT_IDLE: if (rise && zero_ok) begin
                    center <= idx;
                    wz     <= z;
                    left   <= LEFT_W'(HALF - 1);
                    fst    <= FIT_FILL;
                end
                FIT_FILL: if (smp_valid) begin
                    if (left == LEFT_W'(1)) fst <= FIT_SUM;
                    left <= left - LEFT_W'(1);
                end
                FIT_SUM: begin
                    f_num   <= fnum_c;
                    f_den   <= fden_c;
                    f_start <= 1'b1;
                    fst     <= FIT_DIV;
                end
                FIT_DIV: if (f_done) begin
                    ts_valid <= 1'b1;
                    ts       <= {center, {FRAC_W{1'b0}}} - HALF_ONE - f_q;
                    fst      <= FIT_IDLE;
                end
                default: fst <= FIT_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/lsq_pair.sv
// Pairs A and B crossing timestamps and emits A minus B.
// Keeps at most one pending timestamp per side; a repeat on the same side replaces it and flags overrun.
module lsq_pair #(
    parameter int TSF_W = 48
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    a_v,
    input  logic signed [TSF_W-1:0] a_ts,
    input  logic                    b_v,
    input  logic signed [TSF_W-1:0] b_ts,
    output logic                    diff_valid,
    output logic signed [TSF_W-1:0] diff,
    output logic                    overrun
);
    logic                    pa, pb;
    logic signed [TSF_W-1:0] ta, tb;

    // Pending bookkeeping and difference output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pa <= 1'b0; pb <= 1'b0; ta <= '0; tb <= '0;
            diff_valid <= 1'b0; diff <= '0; overrun <= 1'b0;
        end else begin
            diff_valid <= 1'b0;
            overrun    <= 1'b0;
            if (a_v && b_v) begin
                diff_valid <= 1'b1;
                diff       <= a_ts - b_ts;
                overrun    <= pa || pb;
                pa <= 1'b0; pb <= 1'b0;
            end else if (a_v) begin
                if (pb) begin
                    diff_valid <= 1'b1;
                    diff       <= a_ts - tb;
                    pb         <= 1'b0;
                end else begin
                    overrun <= pa;
                    pa      <= 1'b1;
                    ta      <= a_ts;
                end
            end else if (b_v) begin
                if (pa) begin
                    diff_valid <= 1'b1;
                    diff       <= ta - b_ts;
                    pa         <= 1'b0;
                end else begin
                    overrun <= pb;
                    pb      <= 1'b1;
                    tb      <= b_ts;
                end
            end
        end
    end
endmodule

// File: rtl/lsq_crossing_timer.sv
// Top: two least-squares crossing channels feeding the A-minus-B pairing stage.
// Assumes one shared sample strobe for both channels.
module lsq_crossing_timer #(
    parameter int SMP_W  = 16,
    parameter int HALF   = 16,
    parameter int FRAC_W = 16,
    parameter int TS_W   = 32,
    parameter int DIV_W  = 64
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           smp_valid,
    input  logic signed [SMP_W-1:0]        smp_a,
    input  logic signed [SMP_W-1:0]        smp_b,
    input  logic [SMP_W-1:0]               hyst,
    output logic                           diff_valid,
    output logic signed [TS_W+FRAC_W-1:0]  diff_out,
    output logic                           overrun
);
    localparam int NCH   = 2;
    localparam int TSF_W = TS_W + FRAC_W;

    logic signed [SMP_W-1:0] ch_smp [NCH];
    logic                    ch_zok [NCH];
    logic                    ch_tsv [NCH];
    logic signed [TSF_W-1:0] ch_ts  [NCH];

    assign ch_smp[0] = smp_a;
    assign ch_smp[1] = smp_b;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        lsq_chan #(
            .SMP_W(SMP_W), .HALF(HALF), .FRAC_W(FRAC_W), .TS_W(TS_W), .DIV_W(DIV_W)
        ) chan_i (
            .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
            .smp(ch_smp[c]), .hyst(hyst),
            .zero_ok(ch_zok[c]), .ts_valid(ch_tsv[c]), .ts(ch_ts[c])
        );
    end

    lsq_pair #(.TSF_W(TSF_W)) pair_i (
        .clk(clk), .rst_n(rst_n),
        .a_v(ch_tsv[0]), .a_ts(ch_ts[0]),
        .b_v(ch_tsv[1]), .b_ts(ch_ts[1]),
        .diff_valid(diff_valid), .diff(diff_out), .overrun(overrun)
    );
endmodule

// File: rtl/lsq_crossing_timer_chk.sv
// Checker for the timestamper, attached by bind; observes channel outputs and pairing outputs.
module lsq_crossing_timer_chk (
    input logic clk,
    input logic rst_n,
    input logic a_tsv,
    input logic b_tsv,
    input logic a_zok,
    input logic b_zok,
    input logic diff_valid,
    input logic overrun
);
    // R5
    a_ts_needs_zero_chk: assert property (@(posedge clk) disable iff (!rst_n) a_tsv |-> a_zok);
    // R5
    b_ts_needs_zero_chk: assert property (@(posedge clk) disable iff (!rst_n) b_tsv |-> b_zok);
    // R5
    a_zero_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) a_zok |=> a_zok);
    // R7
    diff_after_ts_chk: assert property (@(posedge clk) disable iff (!rst_n) diff_valid |-> $past(a_tsv || b_tsv));
    // R7
    diff_single_chk: assert property (@(posedge clk) disable iff (!rst_n) diff_valid |=> !diff_valid);
    // R8
    overrun_after_ts_chk: assert property (@(posedge clk) disable iff (!rst_n) overrun |-> $past(a_tsv || b_tsv));
endmodule

bind lsq_crossing_timer lsq_crossing_timer_chk chk_i (
    .clk(clk), .rst_n(rst_n),
    .a_tsv(ch_tsv[0]), .b_tsv(ch_tsv[1]),
    .a_zok(ch_zok[0]), .b_zok(ch_zok[1]),
    .diff_valid(diff_valid), .overrun(overrun)
);

// File: tb/lsq_crossing_timer_tb.sv
// Bench: sweeps phase, offset, dither and hysteresis; compares every difference against an arithmetic model.
module lsq_crossing_timer_tb_top;
    localparam int SW = 16, H = 16, FW = 16, TW = 32, DW = 64;
    localparam int NS = 360, GAP = 72;
    localparam real PER = 50.3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic smp_valid = 1'b0;
    logic signed [SW-1:0] smp_a = '0, smp_b = '0;
    logic [SW-1:0] hyst = '0;
    logic diff_valid, overrun;
    logic signed [TW+FW-1:0] diff_out;

    int errs = 0, checks = 0;
    bit finished = 0;
    int ys [2][NS];
    longint ts_at [2][NS];
    bit has_at [2][NS];
    longint exp_d [$];
    longint got_d [$];
    int exp_ovr, got_ovr;
    int unsigned seed = 32'd12345;

    always #4 clk = ~clk;

    lsq_crossing_timer #(.SMP_W(SW), .HALF(H), .FRAC_W(FW), .TS_W(TW), .DIV_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_a(smp_a), .smp_b(smp_b),
        .hyst(hyst), .diff_valid(diff_valid), .diff_out(diff_out), .overrun(overrun)
    );

    // Output monitor, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (diff_valid) got_d.push_back(longint'(diff_out));
            if (overrun) got_ovr++;
        end
    end

    task automatic check(input bit ok, input string what, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=%0d expected=%0d", what, act, expv);
        end
    endtask

    // Channel model: zero level, edges with hysteresis, window fit.
    function automatic void model_chan(input int c, input int hy);
        int z = 0, prev = 0, center = 0, wz = 0;
        bit zok = 0, hi = 0, started = 0, pend = 0;
        longint acc = 0, cnt = 0, sx = 0, sxx = 0, denc;
        for (int x = -H; x < H; x++) begin sx += x; sxx += longint'(x) * x; end
        denc = 2 * H * sxx - sx * sx;
        for (int i = 0; i < NS; i++) begin
            int cur = ys[c][i];
            bit rise = !hi && prev < z && cur >= z;
            bit fall = hi && cur < z - hy;
            has_at[c][i] = 0;
            ts_at[c][i] = 0;
            if (rise) hi = 1;
            if (fall) hi = 0;
            if (rise && zok && !pend) begin
                pend = 1; center = i; wz = z;
            end else if (pend && i == center + H - 1) begin
                longint sy = 0, sxy = 0, num, den, q;
                for (int k = 0; k < 2 * H; k++) begin
                    longint d = ys[c][center - H + k] - wz;
                    sy += d;
                    sxy += d * (k - H);
                end
                num = sy * denc * 65536;
                den = 2 * H * (2 * H * sxy - sx * sy);
                q = num / den;
                ts_at[c][i] = longint'(center) * 65536 - 32768 - q;
                has_at[c][i] = 1;
                pend = 0;
            end
            if (fall) begin
                if (started) begin z = int'(acc / cnt); zok = 1; end
                started = 1; acc = cur; cnt = 1;
            end else if (started) begin
                acc += cur; cnt++;
            end
            prev = cur;
        end
    endfunction

    // Pairing model.
    function automatic void model_pair();
        bit pa = 0, pb = 0;
        longint ta = 0, tb = 0;
        exp_d.delete();
        exp_ovr = 0;
        for (int i = 0; i < NS; i++) begin
            bit a = has_at[0][i], b = has_at[1][i];
            if (a && b) begin
                exp_d.push_back(ts_at[0][i] - ts_at[1][i]);
                if (pa || pb) exp_ovr++;
                pa = 0; pb = 0;
            end else if (a) begin
                if (pb) begin exp_d.push_back(ts_at[0][i] - tb); pb = 0; end
                else begin if (pa) exp_ovr++; pa = 1; ta = ts_at[0][i]; end
            end else if (b) begin
                if (pa) begin exp_d.push_back(ta - ts_at[1][i]); pa = 0; end
                else begin if (pb) exp_ovr++; pb = 1; tb = ts_at[1][i]; end
            end
        end
    endfunction

    task automatic run_case(input real ph, input int offa, input int offb, input int amp,
                            input int noise, input int hy, input int kill_at);
        for (int i = 0; i < NS; i++) begin
            int na, nb;
            seed = seed * 32'd1103515245 + 32'd12345;
            na = int'((seed >> 16) % (2 * noise + 1)) - noise;
            seed = seed * 32'd1103515245 + 32'd12345;
            nb = int'((seed >> 16) % (2 * noise + 1)) - noise;
            ys[0][i] = offa + int'(real'(amp) * $sin(6.283185307179586 * real'(i) / PER)) + na;
            ys[1][i] = offb + int'(real'(amp) * $sin(6.283185307179586 * (real'(i) - ph) / PER)) + nb;
            if (kill_at > 0 && i >= kill_at) ys[1][i] = offb - amp;
        end
        model_chan(0, hy);
        model_chan(1, hy);
        model_pair();
        @(negedge clk);
        rst_n = 1'b0;
        smp_valid = 1'b0;
        hyst = SW'(hy);
        repeat (4) @(negedge clk);
        // R9 reset state
        check(diff_valid == 1'b0, "R9 diff_valid in reset", longint'(diff_valid), 0);
        check(overrun == 1'b0, "R9 overrun in reset", longint'(overrun), 0);
        rst_n = 1'b1;
        got_d.delete();
        got_ovr = 0;
        @(negedge clk);
        check(diff_valid == 1'b0 && overrun == 1'b0, "R9 outputs after reset",
              longint'({diff_valid, overrun}), 0);
        for (int i = 0; i < NS; i++) begin
            smp_a = SW'(ys[0][i]);
            smp_b = SW'(ys[1][i]);
            smp_valid = 1'b1;
            @(negedge clk);
            smp_valid = 1'b0;
            repeat (GAP - 1) @(negedge clk);
        end
        repeat (100) @(negedge clk);
        // R1 R5 R7: exactly the expected number of differences, none before the zero level is valid
        check(got_d.size() == exp_d.size(), "R1 R5 R7 difference count", got_d.size(), exp_d.size());
        for (int k = 0; k < got_d.size() && k < exp_d.size(); k++)
            // R2 R3 R4 R6 R10: value of each paired difference
            check(got_d[k] == exp_d[k], $sformatf("R2 R3 R4 R6 R10 difference %0d", k), got_d[k], exp_d[k]);
        // R8 overrun pulses
        check(got_ovr == exp_ovr, "R8 overrun count", got_ovr, exp_ovr);
    endtask

    initial begin
        run_case(0.0,    0,    0, 2000,  0,  8, 0);
        run_case(7.3,  400, -350, 2000,  4, 16, 0);
        run_case(-11.6, -250, 120, 1800, 20, 64, 0);
        run_case(3.1,  100,  -80, 2000,  6, 24, 200);
        check(exp_ovr > 0, "R8 flat channel must overrun", exp_ovr, 1);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            errs++;
            checks++;
            $display("FAIL R7 watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule